// File: doc/BRIEF.md
# Overflow-Triggered PWM Timer

This block generates one pulse-width-modulated output from an up counter. A prescaler divides the input clock by a power of two chosen by a 3-bit select code. Each enable pulse from the prescaler advances the counter by one. Every time the counter rolls over from its top value to zero, a new period begins and the output goes to its active level. It returns to the inactive level when the count reaches the compare value. It then stays inactive until the next rollover. A period therefore lasts 256 counter steps, and the active phase lasts as many steps as the compare value.

Software configures the block through a simple write port with three registers: control, clock select and compare. Starting the counter does not start the waveform at once. The output stays inactive until the first rollover, so a full dead period always comes first. A write to the compare register goes into a holding buffer. The counter takes the new value only at a rollover, so the pulse already in progress is never cut short or stretched. Clearing the run bit stops the counter, resets it and the prescaler to zero, and forces the output to its inactive level.

Top module: `pwm8_timer`

## Requirements
- R1: After synchronous reset, every register reads as zero and `pwm_out` is 0.
- R2: The write address selects the target register: 0 is control, 1 is clock select (bits 2:0), 2 is compare. In the control register, bit 0 is run, bit 1 is PWM mode, bit 2 is invert and bit 3 is output enable. A write to address 3 has no effect on the output waveform.
- R3: With select code k, the counter advances once every 2^(k+1) input clocks while run is 1.
- R4: After run goes from 0 to 1, the output stays at its inactive level for the first 256 counter steps, up to the first rollover.
- R5: From each rollover, the output is active while the count is below the compare value C, which gives C steps out of every 256. With C = 0 the output is never active.
- R6: With invert = 0 the active level is 1. With invert = 1 the active level is 0 and the inactive level is 1.
- R7: When output enable is 0 or PWM mode is 0, the output stays at the inactive level. Counting continues regardless, so setting output enable while running picks up the waveform in phase.
- R8: A control write that clears run makes the output inactive from the next cycle. It also resets the counter and the prescaler, so the next start begins with a new dead period.
- R9: The compare value in use changes only at a rollover, where it is loaded from the last value written to the compare register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| pwm_out | output | 1 | PWM output |

## Verification
The hardest situations to create from the ports are compare writes that land at a chosen phase of a period, and a stop that lands inside an active phase. In each case the result depends on where the write falls relative to the next rollover. The bench keeps an arithmetic count of the clocks since each start, so it knows the period index and the in-period step. It places writes during the dead period, inside an active phase, and twice within one period to show that the last write wins. Sweeps over select codes and compare values, including 0, 1 and 255, cover the boundaries of the duty range.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;

    // Control register layout, bit 0 at the bottom
    typedef struct packed {
        logic oe;   // bit 3
        logic inv;  // bit 2
        logic pwm;  // bit 1
        logic run;  // bit 0
    } ctrl_t;

    typedef enum logic [1:0] {
        ADDR_CTRL   = 2'd0,
        ADDR_CLKSEL = 2'd1,
        ADDR_CMP    = 2'd2,
        ADDR_RSVD   = 2'd3
    } reg_addr_e;

    // Low-bit mask whose all-ones state marks the last clock of a prescaler interval
    function automatic logic [31:0] div_mask(input int unsigned sel);
        return (32'd2 << sel) - 32'd1;
    endfunction

endpackage

// File: rtl/pwm8_regs.sv
module pwm8_regs
    import pwm8_pkg::*;
#(
    parameter int DW    = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [DW-1:0]    wr_data,
    output ctrl_t            ctrl_q,
    output logic [SEL_W-1:0] sel_q,
    output logic [DW-1:0]    cmp_buf_q
);

    localparam int CTRL_W = $bits(ctrl_t);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            sel_q     <= '0;
            cmp_buf_q <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                ADDR_CTRL:   ctrl_q    <= ctrl_t'(wr_data[CTRL_W-1:0]);
                ADDR_CLKSEL: sel_q     <= wr_data[SEL_W-1:0];
                ADDR_CMP:    cmp_buf_q <= wr_data;
                default:     ;
            endcase
        end
    end

endmodule

// File: rtl/pwm8_prescaler.sv
module pwm8_prescaler
    import pwm8_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    localparam int PRE_W = 2 ** SEL_W;

    logic [PRE_W-1:0] div_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        mask = PRE_W'(div_mask(32'(sel)));
        tick = run && ((div_q & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) div_q <= '0;
        else             div_q <= div_q + PRE_W'(1);
    end

endmodule

// File: rtl/pwm8_core.sv
module pwm8_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] cmp_buf,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cmp_act_q,
    output logic             phase_on_q
);

    logic             at_top;
    logic [CNT_W-1:0] cnt_nxt;

    always_comb begin
        at_top  = (cnt_q == '1);
        cnt_nxt = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cmp_act_q <= '0;
        else if (run && tick && at_top) cmp_act_q <= cmp_buf;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q      <= '0;
            phase_on_q <= 1'b0;
        end else if (tick) begin
            cnt_q <= cnt_nxt;
            if (at_top)                    phase_on_q <= (cmp_buf != '0);
            else if (cnt_nxt == cmp_act_q) phase_on_q <= 1'b0;
        end
    end

endmodule

// File: rtl/pwm8_timer.sv
module pwm8_timer
    import pwm8_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pwm_out
);

    ctrl_t            ctrl_q;
    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] cmp_buf_q;
    logic             tick;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cmp_act_q;
    logic             phase_on_q;
    logic             run_w;
    logic             inv_w;
    logic             oe_w;

    pwm8_regs #(.DW(CNT_W), .SEL_W(SEL_W)) i_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ctrl_q(ctrl_q), .sel_q(sel_q), .cmp_buf_q(cmp_buf_q)
    );

    pwm8_prescaler #(.SEL_W(SEL_W)) i_pre (
        .clk(clk), .rst(rst), .run(run_w), .sel(sel_q), .tick(tick)
    );

    pwm8_core #(.CNT_W(CNT_W)) i_core (
        .clk(clk), .rst(rst), .run(run_w), .tick(tick), .cmp_buf(cmp_buf_q),
        .cnt_q(cnt_q), .cmp_act_q(cmp_act_q), .phase_on_q(phase_on_q)
    );

    always_comb begin
        run_w   = ctrl_q.run;
        inv_w   = ctrl_q.inv;
        oe_w    = ctrl_q.oe;
        pwm_out = (phase_on_q && run_w && ctrl_q.pwm && oe_w) ^ inv_w;
    end

endmodule

// File: rtl/pwm8_checker.sv
module pwm8_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic             wr_run,
    input logic             wr_inv,
    input logic             run,
    input logic             inv,
    input logic             oe,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cmp_act,
    input logic             phase_on,
    input logic             pwm_out
);

    // R8: clearing run forces the inactive level on the following cycle
    assert_stop_inactive_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd0 && !wr_run) |=> (pwm_out == $past(wr_inv)));

    // R4, R5: an active phase begins only at a rollover
    assert_rise_at_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(phase_on) |-> (cnt == '0 && $past(cnt) == '1));

    // R5: a running active phase ends exactly at the compare value
    assert_fall_at_match_R5: assert property (@(posedge clk) disable iff (rst)
        ($fell(phase_on) && run) |-> (cnt == cmp_act));

    // R9: the compare value in use changes only at a rollover
    assert_cmp_load_at_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(cmp_act) |-> (cnt == '0 && $past(cnt) == '1));

    // R3: while running, the counter moves by single steps
    assert_single_step_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(run) && run && !$stable(cnt)) |-> ((cnt - $past(cnt)) == CNT_W'(1)));

    // R4: a fresh start never begins in an active phase
    assert_start_dead_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> !phase_on);

    // R7: output disabled holds the inactive level
    assert_oe_gate_R7: assert property (@(posedge clk) disable iff (rst)
        !oe |-> (pwm_out == inv));

endmodule

bind pwm8_timer pwm8_checker #(.CNT_W(CNT_W)) i_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_run(wr_data[0]), .wr_inv(wr_data[2]),
    .run(run_w), .inv(inv_w), .oe(oe_w),
    .cnt(cnt_q), .cmp_act(cmp_act_q), .phase_on(phase_on_q), .pwm_out(pwm_out)
);

// File: tb/test_pwm8_timer.sv
`timescale 1ns/1ps
module test_pwm8_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       pwm_out;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // reference state: clocks since start, register shadows, compare in use
    int t = 0;
    bit m_run = 0, m_pwm = 0, m_inv = 0, m_oe = 0;
    int m_sel = 0, m_buf = 0, m_act = 0;

    always #4 clk = ~clk;

    pwm8_timer i_pwm8_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out)
    );

    function automatic bit expected_pin();
        int div = 2 << m_sel;
        int n = t / div;
        bit act = m_run && (n >= 256) && ((n % 256) < m_act);
        return (act && m_pwm && m_oe) ^ m_inv;
    endfunction

    task automatic step(input bit we, input logic [1:0] a, input logic [7:0] d, input string req);
        bit e;
        wr_en = we; wr_addr = a; wr_data = d;
        @(posedge clk);
        if (m_run) begin
            int div = 2 << m_sel;
            t++;
            if ((t % div) == 0 && ((t / div) % 256) == 0) m_act = m_buf;
        end
        if (we) begin
            case (a)
                2'd0: begin
                    if (m_run != d[0]) t = 0;
                    m_run = d[0]; m_pwm = d[1]; m_inv = d[2]; m_oe = d[3];
                end
                2'd1: m_sel = int'(d[2:0]);
                2'd2: m_buf = int'(d);
                default: ;
            endcase
        end
        #1;
        wr_en = 1'b0;
        e = expected_pin();
        vectors++;
        if (pwm_out !== e) begin
            errors++;
            $display("FAIL %s t=%0d actual=%b expected=%b", req, t, pwm_out, e);
        end
    endtask

    task automatic idle(input int cycles, input string req);
        for (int i = 0; i < cycles; i++) step(1'b0, 2'd0, 8'd0, req);
    endtask

    function automatic logic [7:0] ctrl(input bit run, input bit pwm, input bit inv, input bit oe);
        return {4'd0, oe, inv, pwm, run};
    endfunction

    task automatic start(input int sel, input int cmp, input bit inv, input bit oe,
                         input bit pwm, input string req);
        step(1'b1, 2'd0, ctrl(0, pwm, inv, oe), req);
        step(1'b1, 2'd1, 8'(sel), req);
        step(1'b1, 2'd2, 8'(cmp), req);
        step(1'b1, 2'd0, ctrl(1, pwm, inv, oe), req);
    endtask

    initial begin
        #(8 * 180000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        int cmps[8] = '{0, 1, 2, 77, 128, 200, 254, 255};

        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        vectors++;
        if (pwm_out !== 1'b0) begin
            errors++;
            $display("FAIL R1 actual=%b expected=0", pwm_out);
        end
        rst = 1'b0;
        idle(4, "R1");

        // R6, R7: idle with invert set sits high
        step(1'b1, 2'd0, ctrl(0, 1, 1, 0), "R6 R7");
        idle(3, "R6 R7");

        // R3, R4, R5, R6: sweep select codes and compare values
        for (int s = 0; s < 3; s++) begin
            for (int c = 0; c < 8; c++) begin
                start(s, cmps[c], bit'(c % 2), 1'b1, 1'b1, "R3 R5 R6");
                idle(3 * 256 * (2 << s), "R3 R4 R5 R6");
            end
        end
        start(3, 90, 1'b0, 1'b1, 1'b1, "R3");
        idle(2 * 256 * 16, "R3 R5");
        start(4, 33, 1'b1, 1'b1, 1'b1, "R3");
        idle(2 * 256 * 32, "R3 R5 R6");

        // R9: buffered compare, loaded at rollover, last write wins
        start(0, 100, 1'b0, 1'b1, 1'b1, "R9");
        idle(100, "R9 dead");
        step(1'b1, 2'd2, 8'd50, "R9");
        idle(512 + 40 - t, "R9");
        step(1'b1, 2'd2, 8'd200, "R9 mid-active");
        idle(5, "R9");
        step(1'b1, 2'd2, 8'd30, "R9 last-wins");
        idle(3 * 512, "R9");

        // R2: write to the reserved address leaves the waveform alone
        step(1'b1, 2'd3, 8'hFF, "R2");
        idle(600, "R2");

        // R8: stop inside an active phase, then restart with a new dead period
        start(1, 180, 1'b1, 1'b1, 1'b1, "R8");
        idle(1024 + 100, "R8");
        step(1'b1, 2'd0, ctrl(0, 1, 1, 1), "R8 stop");
        idle(20, "R8");
        step(1'b1, 2'd0, ctrl(1, 1, 1, 1), "R8 restart");
        idle(1100, "R4 R8");

        // R7: output enable raised while running keeps phase
        start(0, 60, 1'b0, 1'b0, 1'b1, "R7");
        idle(700, "R7");
        step(1'b1, 2'd0, ctrl(1, 1, 0, 1), "R7 enable");
        idle(600, "R7");

        // R7: PWM mode off holds inactive level
        start(0, 120, 1'b0, 1'b1, 1'b0, "R7");
        idle(700, "R7 mode-off");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule